// File: doc/BRIEF.md
# Destination Address Screen for Received Ethernet Frames

This block decides whether a received Ethernet frame should be kept, using only the frame's 48-bit destination address. It sees the address as a byte stream at the head of the frame, first byte on the wire first. A frame-start pulse opens each frame. Once six address bytes have been taken, the block gives a verdict. Bytes after the sixth are not looked at.

The verdict depends on the kind of address. A unicast address, where bit 0 of the first byte is clear, must equal the programmed station address exactly. A group address passes when it is the all-ones broadcast address, or when its entry in a 256-entry hash table is set. The hash index comes from a reflected CRC-32 of the six address bytes. A promiscuous control bit overrides all of this and keeps every frame.

The station address, the hash table and the control bit are loaded through a 32-bit write port. Writes go to word addresses 0 to 10. The verdict is held on `keepFrame` and is marked by a one-cycle `verdictDone` strobe.

Top module: `dest_addr_screen`

## Requirements
- R1: After reset, `keepFrame` and `verdictDone` are 0, all eight hash words are zero and the promiscuous bit is clear, so a group address that is not broadcast is rejected.
- R2: The hash index of a group address is found as follows. A CRC-32 is preset to 0xFFFFFFFF, uses the reflected polynomial 0xEDB88320, and takes the six address bytes in wire order, each byte least significant bit first. The 32-bit result is bit-reversed, and the top 8 bits of the reversed value are the index.
- R3: Hash entry i lives in the hash word at write address i[7:5], in bit 31 - i[4:0]. So entry 0 is bit 31 of word 0 and entry 255 is bit 0 of word 7.
- R4: Station words are laid out as follows. Word 8 holds address bytes 5, 4, 3, 2 from bit 31 downward. Word 9 holds byte 1 in bits 31:24 and byte 0 in bits 23:16. Bits 15:0 of a write to word 9 have no effect. Byte 0 is the first byte on the wire.
- R5: A unicast destination is accepted only when all six bytes equal the station address. The hash table has no effect on unicast frames.
- R6: A group destination is accepted when its hash entry is 1, and it is otherwise rejected. The broadcast address FF:FF:FF:FF:FF:FF is always accepted.
- R7: Bit 0 of word 10 is the promiscuous bit. While it is 1, every frame is accepted.
- R8: `verdictDone` is high for exactly one cycle, starting one clock after the edge that samples the sixth address byte, and `keepFrame` takes its new value at that same edge. `keepFrame` then holds until the next `frameStart`, which clears it to 0.
- R9: Bytes offered after the sixth byte of a frame are ignored: they change neither `keepFrame` nor `verdictDone`. A `frameStart` restarts collection at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStart | input | 1 | One-cycle pulse before the first address byte of a frame |
| byteValid | input | 1 | `byteData` carries an address byte this cycle |
| byteData | input | 8 | Received byte |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrAddr | input | 4 | Configuration word address (0-7 hash, 8-9 station, 10 control) |
| cfgWrData | input | 32 | Configuration write data |
| keepFrame | output | 1 | Accept verdict, held until the next frame start |
| verdictDone | output | 1 | One-cycle strobe when the verdict is valid |

## Verification
The assertions take for granted that `frameStart` never arrives in the same cycle as a valid byte, and that a new frame does not open until the previous verdict has been given. The stimulus respects both: it pulses `frameStart` on its own and waits out the verdict strobe before the next frame. It changes configuration only between frames, so a verdict never depends on a write that lands during address collection. Random destinations are steered toward the station address, broadcast and group addresses so that every acceptance path is exercised.

// File: rtl/addr_screen_pkg.sv
package addr_screen_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int HASH_WORDS = 8;
  localparam int WORD_W     = 32;
  localparam int HASH_BITS  = $clog2(HASH_WORDS * WORD_W);
  localparam int SEL_W      = $clog2(HASH_WORDS);
  localparam int BIT_W      = $clog2(WORD_W);
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam int CFG_AW     = 4;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef struct packed {
    logic             clear;
    logic             take;
    logic             last;
    logic [CNT_W-1:0] slot;
  } strobe_t;

  function automatic logic [31:0] crcStep(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/addr_screen_ctrl.sv
module addr_screen_ctrl
  import addr_screen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameStart,
  input  logic    byteValid,
  output strobe_t stb
);
  logic [CNT_W-1:0] byteCnt;
  logic             takeByte;

  assign takeByte = byteValid && !frameStart && (byteCnt < CNT_W'(ADDR_BYTES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= CNT_W'(ADDR_BYTES);
    end else if (frameStart) begin
      byteCnt <= '0;
    end else if (takeByte) begin
      byteCnt <= byteCnt + 1'b1;
    end
  end

  always_comb begin
    stb.clear = frameStart;
    stb.take  = takeByte;
    stb.last  = takeByte && (byteCnt == CNT_W'(ADDR_BYTES - 1));
    stb.slot  = byteCnt;
  end

  // R9: a frame start restarts collection at byte 0
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> byteCnt == '0);

  // R9: once six bytes are in, further bytes leave the count alone
  assert_extra_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !frameStart && byteCnt == CNT_W'(ADDR_BYTES)) |=> byteCnt == CNT_W'(ADDR_BYTES));
endmodule

// File: rtl/addr_screen_dp.sv
module addr_screen_dp
  import addr_screen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [7:0]        byteData,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgWrAddr,
  input  logic [WORD_W-1:0] cfgWrData,
  output logic              keepFrame,
  output logic              verdictDone
);
  localparam logic [CFG_AW-1:0] ADDR_ST_HI = CFG_AW'(HASH_WORDS);
  localparam logic [CFG_AW-1:0] ADDR_ST_LO = CFG_AW'(HASH_WORDS + 1);
  localparam logic [CFG_AW-1:0] ADDR_CTRL  = CFG_AW'(HASH_WORDS + 2);

  logic [HASH_WORDS-1:0][WORD_W-1:0] hashTbl;
  logic [WORD_W-1:0]                 stationHi;
  logic [15:0]                       stationLo;
  logic                              promisc;
  logic [31:0]                       crcReg;
  logic [ADDR_BYTES-1:0][7:0]        destAddr;
  logic                              evalPending;

  // configuration words
  for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hash
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hashTbl[w] <= '0;
      else if (cfgWrEn && cfgWrAddr == CFG_AW'(w)) hashTbl[w] <= cfgWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stationHi <= '0;
      stationLo <= '0;
      promisc   <= 1'b0;
    end else if (cfgWrEn) begin
      if (cfgWrAddr == ADDR_ST_HI) stationHi <= cfgWrData;
      if (cfgWrAddr == ADDR_ST_LO) stationLo <= cfgWrData[WORD_W-1 -: 16];
      if (cfgWrAddr == ADDR_CTRL)  promisc   <= cfgWrData[0];
    end
  end

  // address capture and running CRC
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg      <= '1;
      destAddr    <= '0;
      evalPending <= 1'b0;
    end else begin
      evalPending <= stb.last;
      if (stb.clear) begin
        crcReg   <= '1;
        destAddr <= '0;
      end else if (stb.take) begin
        crcReg             <= crcStep(crcReg, byteData);
        destAddr[stb.slot] <= byteData;
      end
    end
  end

  // verdict logic
  logic [HASH_BITS-1:0]       hashIdx;
  logic [SEL_W-1:0]           wordSel;
  logic [BIT_W-1:0]           bitSel;
  logic [WORD_W-1:0]          hashRow;
  logic                       hashHit;
  logic [ADDR_BYTES-1:0][7:0] stationAddr;
  logic                       isGroup;
  logic                       isBcast;
  logic                       stationHit;
  logic                       verdictNext;

  always_comb begin
    // top bits of the reversed CRC are the low CRC bits, reversed
    for (int b = 0; b < HASH_BITS; b++) hashIdx[HASH_BITS-1-b] = crcReg[b];
    wordSel = hashIdx[HASH_BITS-1 -: SEL_W];
    bitSel  = hashIdx[BIT_W-1:0];
    hashRow = hashTbl[wordSel];
    hashHit = hashRow[~bitSel];
    stationAddr[5] = stationHi[31:24];
    stationAddr[4] = stationHi[23:16];
    stationAddr[3] = stationHi[15:8];
    stationAddr[2] = stationHi[7:0];
    stationAddr[1] = stationLo[15:8];
    stationAddr[0] = stationLo[7:0];
    isGroup    = destAddr[0][0];
    isBcast    = &destAddr;
    stationHit = (destAddr == stationAddr);
    verdictNext = promisc || (isGroup ? (isBcast || hashHit) : stationHit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keepFrame   <= 1'b0;
      verdictDone <= 1'b0;
    end else begin
      verdictDone <= evalPending;
      if (stb.clear)        keepFrame <= 1'b0;
      else if (evalPending) keepFrame <= verdictNext;
    end
  end

  // R7: promiscuous mode forces acceptance
  assert_promisc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evalPending && promisc) |=> keepFrame);

  // R6: broadcast always passes
  assert_bcast_R6: assert property (@(posedge clk) disable iff (!rstN)
    (evalPending && isBcast) |=> keepFrame);

  // R8: the verdict holds between evaluations and frame starts
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!evalPending && !stb.clear) |=> $stable(keepFrame));

  // R8: the done strobe lasts a single cycle
  assert_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    verdictDone |=> !verdictDone);

  // R8: a frame start clears the verdict
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> !keepFrame);
endmodule

// File: rtl/dest_addr_screen.sv
module dest_addr_screen
  import addr_screen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgWrAddr,
  input  logic [WORD_W-1:0] cfgWrData,
  output logic              keepFrame,
  output logic              verdictDone
);
  strobe_t stb;

  addr_screen_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .byteValid  (byteValid),
    .stb        (stb)
  );

  addr_screen_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .byteData    (byteData),
    .cfgWrEn     (cfgWrEn),
    .cfgWrAddr   (cfgWrAddr),
    .cfgWrData   (cfgWrData),
    .keepFrame   (keepFrame),
    .verdictDone (verdictDone)
  );
endmodule

// File: tb/dest_addr_screen_tb.sv
module dest_addr_screen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgWrAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        keepFrame;
  logic        verdictDone;

  int checks = 0;
  int errors = 0;

  logic [31:0] shHash [8];
  logic [31:0] shHi;
  logic [15:0] shLo;
  logic        shProm;

  always #4 clk = ~clk;

  dest_addr_screen u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .byteValid(byteValid),
    .byteData(byteData), .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr),
    .cfgWrData(cfgWrData), .keepFrame(keepFrame), .verdictDone(verdictDone)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R2: bench reference of the hash index
  function automatic logic [7:0] refIndex(logic [47:0] d);
    logic [31:0] c;
    logic [31:0] rev;
    logic fb;
    c = 32'hFFFFFFFF;
    for (int k = 0; k < 48; k++) begin
      fb = c[0] ^ d[k];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    for (int k = 0; k < 32; k++) rev[k] = c[31-k];
    return rev[31:24];
  endfunction

  function automatic logic refKeep(logic [47:0] d);
    logic [7:0] ix;
    logic [47:0] st;
    ix = refIndex(d);
    st = {shHi, shLo};
    // byte i of d is d[8*i +: 8]; station byte 5 is shHi[31:24]
    if (shProm) return 1'b1;
    if (d[0]) begin
      if (d == 48'hFFFF_FFFF_FFFF) return 1'b1;
      return shHash[ix[7:5]][31 - ix[4:0]];
    end
    return d == {st[47:40], st[39:32], st[31:24], st[23:16], st[15:8], st[7:0]};
  endfunction

  function automatic logic [47:0] stationDest();
    logic [47:0] d;
    d[47:40] = shHi[31:24]; d[39:32] = shHi[23:16];
    d[31:24] = shHi[15:8];  d[23:16] = shHi[7:0];
    d[15:8]  = shLo[15:8];  d[7:0]   = shLo[7:0];
    return d;
  endfunction

  task automatic cfgWrite(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrAddr = a; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (a < 4'd8) shHash[a[2:0]] = v;
    else if (a == 4'd8) shHi = v;
    else if (a == 4'd9) shLo = v[31:16];
    else if (a == 4'd10) shProm = v[0];
  endtask

  task automatic runFrame(input logic [47:0] d, input string req);
    logic expK;
    expK = refKeep(d);
    @(negedge clk); frameStart = 1'b1;
    @(negedge clk); frameStart = 1'b0;
    chk({req, " cleared at start R8"}, {31'd0, keepFrame}, 32'd0);
    for (int k = 0; k < 6; k++) begin
      byteValid = 1'b1; byteData = d[8*k +: 8];
      @(negedge clk);
    end
    byteValid = 1'b0;
    @(negedge clk);
    chk({req, " done strobe R8"}, {31'd0, verdictDone}, 32'd1);
    chk({req, " verdict"}, {31'd0, keepFrame}, {31'd0, expK});
    @(negedge clk);
    chk({req, " strobe one cycle R8"}, {31'd0, verdictDone}, 32'd0);
    chk({req, " verdict held R8"}, {31'd0, keepFrame}, {31'd0, expK});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] d;
    logic [7:0] ix;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 8; k++) shHash[k] = '0;
    shHi = '0; shLo = '0; shProm = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset keepFrame", {31'd0, keepFrame}, 32'd0);
    chk("R1 reset verdictDone", {31'd0, verdictDone}, 32'd0);

    // R1: empty table rejects a group address
    runFrame(48'h0000_5E00_0001, "R1 empty table group");
    runFrame(48'hFFFF_FFFF_FFFF, "R6 broadcast");

    // R4: station address layout, low half of word 9 ignored
    cfgWrite(4'd8, 32'h1234_5678);
    cfgWrite(4'd9, 32'h9ABC_FFFF);
    d = stationDest();
    chk("R4 station byte0", {24'd0, d[7:0]}, 32'hBC);
    runFrame(d, "R5 R4 station match");
    runFrame(d ^ 48'h0100_0000_0000, "R5 station mismatch");
    cfgWrite(4'd9, 32'h9ABC_0000);
    runFrame(d, "R4 low bits of word 9 no effect");

    // R3: set exactly the entry of one group address
    d = 48'h3322_1100_5E01;
    ix = refIndex(d);
    cfgWrite({1'b0, ix[7:5]}, 32'h1 << (31 - ix[4:0]));
    runFrame(d, "R2 R3 hash entry set");
    cfgWrite({1'b0, ix[7:5]}, ~(32'h1 << (31 - ix[4:0])));
    runFrame(d, "R3 other bits only");
    cfgWrite({1'b0, ix[7:5]}, 32'h0);
    // R5: hash table does not admit unicast
    for (int k = 0; k < 8; k++) cfgWrite(k[3:0], 32'hFFFF_FFFF);
    runFrame(48'h0000_0000_0002, "R5 unicast ignores hash");
    runFrame(48'h0000_0000_0003, "R6 group with full table");
    for (int k = 0; k < 8; k++) cfgWrite(k[3:0], 32'h0);

    // R7: promiscuous
    cfgWrite(4'd10, 32'h1);
    runFrame(48'h0000_0000_0002, "R7 promisc unicast");
    runFrame(48'h0000_0000_0003, "R7 promisc group");
    cfgWrite(4'd10, 32'h0);

    // R9: extra bytes after the sixth change nothing
    d = stationDest();
    runFrame(d, "R9 setup");
    for (int k = 0; k < 4; k++) begin
      byteValid = 1'b1; byteData = 8'hA5 + k[7:0];
      @(negedge clk);
      chk("R9 no strobe from extra bytes", {31'd0, verdictDone}, 32'd0);
      chk("R9 verdict kept", {31'd0, keepFrame}, 32'd1);
    end
    byteValid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 no late strobe", {31'd0, verdictDone}, 32'd0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int pick;
      pick = $urandom_range(0, 9);
      if (pick == 0) cfgWrite($urandom_range(0, 7), $urandom());
      if (pick == 1) cfgWrite(4'd10, {31'd0, ($urandom_range(0, 7) == 0) ? 1'b1 : 1'b0});
      d = {$urandom(), $urandom()} ;
      case ($urandom_range(0, 4))
        0: d = stationDest();
        1: d = 48'hFFFF_FFFF_FFFF;
        2: d[0] = 1'b1;
        default: d[0] = 1'b0;
      endcase
      runFrame(d, "R2 R5 R6 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule